// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps two word-aligned stack pointers for a small processor core: a main pointer for the kernel and exception handlers, and a process pointer for application tasks. It presents one of them as the active stack pointer. Which one is active depends on two things: whether the core runs in thread or handler mode, and a select bit in a two-bit control register.

The datapath asks for a push or a pop. The block returns the word address for that stack access in the same cycle and updates the active pointer at the next clock edge. Boot logic loads the main pointer from the first vector word it fetches. Software can write either pointer and the control register. Exception entry and exception return move the block between thread and handler mode. On a return to thread mode, the exception-return code rewrites the select bit.

Top module: `bsp_unit`

## Requirements
- R1: After reset the main pointer reads 0, the control register reads 0, the block is in thread mode, and the main pointer is active (`proc_active` low).
- R2: A cycle with `boot_vld` high loads the main pointer from `boot_word` with bits [1:0] cleared. This load overrides any other update of the main pointer in the same cycle.
- R3: In thread mode, control bit 1 chooses the active pointer: 0 selects the main pointer and 1 selects the process pointer. Control bit 0 is a privilege flag that is stored and read back unchanged.
- R4: In handler mode the main pointer is always active, and pushes and pops change only the main pointer, whatever control bit 1 holds.
- R5: A push drives `stk_addr` to the active pointer minus 4 with `stk_vld` high, and the active pointer takes that value at the next edge.
- R6: A pop drives `stk_addr` to the active pointer itself with `stk_vld` high, and the active pointer grows by 4 at the next edge. When push and pop are both requested, the push is performed and the pop is ignored.
- R7: Bits [1:0] of both pointers are always zero. A software write stores its data with bits [1:0] cleared.
- R8: A software write to a pointer overrides a push or pop update of that same pointer in the same cycle.
- R9: Exception entry puts the block in handler mode, which makes the main pointer active at the next edge. The control register is not changed.
- R10: Exception return is acted on only in handler mode. If bit 3 of `exc_code` is 1, the block goes to thread mode and control bit 1 takes bit 2 of `exc_code`. If bit 3 is 0, the block stays in handler mode and the control register is unchanged. Exception return in thread mode is ignored.
- R11: Events in one cycle are ordered as follows. A push or pop uses the pointer that was active before any mode change in that cycle. Exception entry wins over exception return. The select bit from an exception return wins over a control write in the same cycle, while the written privilege bit still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_vld | input | 1 | Load the main pointer from the boot vector word |
| boot_word | input | 32 | First vector word fetched at boot |
| push_req | input | 1 | Push one word onto the active stack |
| pop_req | input | 1 | Pop one word from the active stack |
| stk_vld | output | 1 | A stack access address is presented |
| stk_addr | output | 32 | Word address of the current push or pop |
| wr_main | input | 1 | Software write of the main pointer |
| wr_proc | input | 1 | Software write of the process pointer |
| wr_data | input | 32 | Data for software pointer writes |
| ctrl_wr | input | 1 | Software write of the control register |
| ctrl_wdata | input | 2 | Control data: bit 1 select, bit 0 privilege |
| exc_entry | input | 1 | Exception entry event |
| exc_return | input | 1 | Exception return event |
| exc_code | input | 32 | Exception-return code (bit 3 return mode, bit 2 stack) |
| sp_active | output | 32 | Currently active stack pointer |
| sp_main | output | 32 | Main pointer, for software reads |
| sp_proc | output | 32 | Process pointer, for software reads |
| in_handler | output | 1 | High in handler mode |
| ctrl_rd | output | 2 | Control register read-back |
| proc_active | output | 1 | High when the process pointer is active |

## Verification
Pushes and pops are applied in both modes and with both select settings, so that an update landing on the wrong bank or in the wrong direction shows up at once. Simultaneous push and pop requests check which operation wins. Cycles that combine a push with an exception event, a pointer write, or a control write check the stated event order. Exception returns carrying every combination of code bits 3 and 2, issued in both modes, check the select update and the rule that a return in thread mode is ignored. Unaligned write data and unaligned boot words check that bits [1:0] are always cleared.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int CTRL_W    = 2;
    localparam int CTRL_PRIV = 0;
    localparam int CTRL_SEL  = 1;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // sel sits in bit 1, priv in bit 0, matching the control layout
    typedef struct packed {
        logic sel;
        logic priv;
    } ctrl_t;

    typedef struct packed {
        logic  handler;
        ctrl_t ctrl;
    } mode_t;

endpackage

// File: rtl/bsp_step.sv
// Address and next-value generation for one word-sized stack access.
module bsp_step #(
    parameter int DW         = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic [DW-1:0]         ptr_i,
    input  bsp_pkg::stk_op_e      op_i,
    output logic [DW-1:0]         addr_o,
    output logic [DW-1:0]         nxt_o
);
    import bsp_pkg::*;

    localparam logic [DW-1:0] STEP = DW'(STEP_BYTES);

    logic [DW-1:0] dec_w;
    logic [DW-1:0] inc_w;

    always_comb begin
        dec_w = ptr_i - STEP;
        inc_w = ptr_i + STEP;
        // full-descending stack: push predecrements, pop reads then increments
        unique case (op_i)
            STK_PUSH: begin
                addr_o = dec_w;
                nxt_o  = dec_w;
            end
            STK_POP: begin
                addr_o = ptr_i;
                nxt_o  = inc_w;
            end
            default: begin
                addr_o = ptr_i;
                nxt_o  = ptr_i;
            end
        endcase
    end

endmodule

// File: rtl/bsp_mode_ctl.sv
// Mode and control-register next state, plus active-bank selection.
module bsp_mode_ctl #(
    parameter int DW           = 32,
    parameter int RET_SP_BIT   = 2,
    parameter int RET_MODE_BIT = 3
) (
    input  bsp_pkg::mode_t          mode_q_i,
    input  logic                    ctrl_wr_i,
    input  logic [bsp_pkg::CTRL_W-1:0] ctrl_wdata_i,
    input  logic                    exc_entry_i,
    input  logic                    exc_return_i,
    input  logic [DW-1:0]           exc_code_i,
    output bsp_pkg::mode_t          mode_d_o,
    output logic                    use_proc_o
);
    import bsp_pkg::*;

    logic ret_taken;
    logic ret_to_thread;

    always_comb begin
        // handler mode overrides the select bit
        use_proc_o    = !mode_q_i.handler && mode_q_i.ctrl.sel;

        ret_taken     = exc_return_i && mode_q_i.handler && !exc_entry_i;
        ret_to_thread = ret_taken && exc_code_i[RET_MODE_BIT];

        mode_d_o = mode_q_i;
        if (ctrl_wr_i) begin
            mode_d_o.ctrl.sel  = ctrl_wdata_i[CTRL_SEL];
            mode_d_o.ctrl.priv = ctrl_wdata_i[CTRL_PRIV];
        end

        if (exc_entry_i) begin
            mode_d_o.handler = 1'b1;
        end else if (ret_to_thread) begin
            mode_d_o.handler  = 1'b0;
            mode_d_o.ctrl.sel = exc_code_i[RET_SP_BIT];
        end
    end

endmodule

// File: rtl/bsp_unit.sv
// Banked stack pointer unit: main and process pointers with one active view.
module bsp_unit #(
    parameter int DW           = 32,
    parameter int STEP_BYTES   = 4,
    parameter int RET_SP_BIT   = 2,
    parameter int RET_MODE_BIT = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       boot_vld,
    input  logic [DW-1:0]              boot_word,
    input  logic                       push_req,
    input  logic                       pop_req,
    output logic                       stk_vld,
    output logic [DW-1:0]              stk_addr,
    input  logic                       wr_main,
    input  logic                       wr_proc,
    input  logic [DW-1:0]              wr_data,
    input  logic                       ctrl_wr,
    input  logic [bsp_pkg::CTRL_W-1:0] ctrl_wdata,
    input  logic                       exc_entry,
    input  logic                       exc_return,
    input  logic [DW-1:0]              exc_code,
    output logic [DW-1:0]              sp_active,
    output logic [DW-1:0]              sp_main,
    output logic [DW-1:0]              sp_proc,
    output logic                       in_handler,
    output logic [bsp_pkg::CTRL_W-1:0] ctrl_rd,
    output logic                       proc_active
);
    import bsp_pkg::*;

    localparam int NBANK   = 2;
    localparam int ALIGN_W = $clog2(STEP_BYTES);
    localparam int MAIN_IX = 0;
    localparam int PROC_IX = 1;

    typedef struct packed {
        logic [DW-1:0] main_sp;
        logic [DW-1:0] proc_sp;
        mode_t         mode;
    } state_t;

    state_t st_q, st_d;

    stk_op_e         op;
    logic            use_proc;
    logic [DW-1:0]   act_ptr;
    logic [DW-1:0]   step_addr;
    logic [DW-1:0]   step_nxt;
    mode_t           mode_nxt;
    logic [NBANK-1:0] sw_wr;
    logic [DW-1:0]   wr_aligned;
    logic [DW-1:0]   boot_aligned;

    always_comb begin
        // push has precedence over a simultaneous pop
        if (push_req)     op = STK_PUSH;
        else if (pop_req) op = STK_POP;
        else              op = STK_IDLE;
        sw_wr        = {wr_proc, wr_main};
        wr_aligned   = {wr_data[DW-1:ALIGN_W], {ALIGN_W{1'b0}}};
        boot_aligned = {boot_word[DW-1:ALIGN_W], {ALIGN_W{1'b0}}};
        act_ptr      = use_proc ? st_q.proc_sp : st_q.main_sp;
    end

    bsp_mode_ctl #(
        .DW           (DW),
        .RET_SP_BIT   (RET_SP_BIT),
        .RET_MODE_BIT (RET_MODE_BIT)
    ) mode_i (
        .mode_q_i     (st_q.mode),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_wdata_i (ctrl_wdata),
        .exc_entry_i  (exc_entry),
        .exc_return_i (exc_return),
        .exc_code_i   (exc_code),
        .mode_d_o     (mode_nxt),
        .use_proc_o   (use_proc)
    );

    bsp_step #(
        .DW         (DW),
        .STEP_BYTES (STEP_BYTES)
    ) step_i (
        .ptr_i  (act_ptr),
        .op_i   (op),
        .addr_o (step_addr),
        .nxt_o  (step_nxt)
    );

    // Per-bank next value: stack op on the active bank, then software write,
    // then (main bank only) the boot load.
    for (genvar b = 0; b < NBANK; b++) begin : bank_g
        logic [DW-1:0] cur;
        logic [DW-1:0] nxt;
        logic          sel_here;
        always_comb begin
            cur      = (b == MAIN_IX) ? st_q.main_sp : st_q.proc_sp;
            sel_here = (b == PROC_IX) ? use_proc : !use_proc;
            nxt      = cur;
            if (op != STK_IDLE && sel_here) nxt = step_nxt;
            if (sw_wr[b])                   nxt = wr_aligned;
        end
    end

    logic [DW-1:0] main_nxt;
    if (1) begin : boot_g
        always_comb begin
            main_nxt = boot_vld ? boot_aligned : bank_g[MAIN_IX].nxt;
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.main_sp = main_nxt;
        st_d.proc_sp = bank_g[PROC_IX].nxt;
        st_d.mode    = mode_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stk_vld     = (op != STK_IDLE);
        stk_addr    = step_addr;
        sp_active   = act_ptr;
        sp_main     = st_q.main_sp;
        sp_proc     = st_q.proc_sp;
        in_handler  = st_q.mode.handler;
        ctrl_rd     = st_q.mode.ctrl;
        proc_active = use_proc;
    end

endmodule

// File: rtl/bsp_unit_chk.sv
module bsp_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boot_vld,
    input logic          push_req,
    input logic          pop_req,
    input logic          wr_main,
    input logic          wr_proc,
    input logic          ctrl_wr,
    input logic          exc_entry,
    input logic          exc_return,
    input logic [DW-1:0] exc_code,
    input logic [DW-1:0] sp_active,
    input logic [DW-1:0] sp_main,
    input logic [DW-1:0] sp_proc,
    input logic          in_handler,
    input logic [1:0]    ctrl_rd,
    input logic          proc_active
);
    logic quiet;
    assign quiet = !boot_vld && !wr_main && !wr_proc && !ctrl_wr && !exc_entry && !exc_return;

    a_r4_handler_main: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |-> !proc_active);

    a_r3_thread_select: assert property (@(posedge clk) disable iff (!rst_n)
        !in_handler |-> (proc_active == ctrl_rd[1]));

    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_main[1:0] == 2'b00) && (sp_proc[1:0] == 2'b00));

    a_r5_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && quiet) |=> (sp_active == $past(sp_active) - DW'(4)));

    a_r6_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && quiet) |=> (sp_active == $past(sp_active) + DW'(4)));

    a_r9_entry_handler: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (in_handler && !proc_active));

    a_r10_return_thread: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_entry && in_handler && exc_code[3])
        |=> (!in_handler && (proc_active == $past(exc_code[2]))));

    a_r10_return_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_entry && !in_handler) |=> !in_handler);
endmodule

bind bsp_unit bsp_unit_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_vld    (boot_vld),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .wr_main     (wr_main),
    .wr_proc     (wr_proc),
    .ctrl_wr     (ctrl_wr),
    .exc_entry   (exc_entry),
    .exc_return  (exc_return),
    .exc_code    (exc_code),
    .sp_active   (sp_active),
    .sp_main     (sp_main),
    .sp_proc     (sp_proc),
    .in_handler  (in_handler),
    .ctrl_rd     (ctrl_rd),
    .proc_active (proc_active)
);

// File: tb/bsp_unit_tb_top.sv
module bsp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_vld = 0, push_req = 0, pop_req = 0;
    logic [31:0] boot_word = '0, wr_data = '0, exc_code = '0;
    logic        wr_main = 0, wr_proc = 0, ctrl_wr = 0, exc_entry = 0, exc_return = 0;
    logic [1:0]  ctrl_wdata = '0;
    logic        stk_vld, in_handler, proc_active;
    logic [31:0] stk_addr, sp_active, sp_main, sp_proc;
    logic [1:0]  ctrl_rd;

    int total = 0, bad = 0;
    bit done = 0;

    // bench model of the architectural state
    logic [31:0] m_main, m_proc;
    logic        m_hnd, m_known;
    logic [1:0]  m_ctl;

    always #2.5 clk = ~clk;

    bsp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .boot_vld(boot_vld), .boot_word(boot_word),
        .push_req(push_req), .pop_req(pop_req), .stk_vld(stk_vld), .stk_addr(stk_addr),
        .wr_main(wr_main), .wr_proc(wr_proc), .wr_data(wr_data),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .exc_entry(exc_entry), .exc_return(exc_return), .exc_code(exc_code),
        .sp_active(sp_active), .sp_main(sp_main), .sp_proc(sp_proc),
        .in_handler(in_handler), .ctrl_rd(ctrl_rd), .proc_active(proc_active)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_use_proc();
        return !m_hnd && m_ctl[1];
    endfunction

    task automatic idle();
        boot_vld = 0; push_req = 0; pop_req = 0; wr_main = 0; wr_proc = 0;
        ctrl_wr = 0; exc_entry = 0; exc_return = 0;
    endtask

    // inputs already driven (after a negedge); check address, clock, compare state
    task automatic step(string tag);
        logic        up;
        logic [31:0] a, v, n_main, n_proc;
        logic [1:0]  n_ctl;
        logic        n_hnd;
        #1;
        up = m_use_proc();
        a  = up ? m_proc : m_main;
        if (push_req || pop_req) begin
            if (!up || m_known) begin
                chk({tag, " stk_addr R5 R6"}, stk_addr, push_req ? a - 32'd4 : a);
            end
            chk({tag, " stk_vld R5"}, 32'(stk_vld), 32'd1);
        end
        n_main = m_main; n_proc = m_proc;
        if (push_req || pop_req) begin
            v = push_req ? a - 32'd4 : a + 32'd4;
            if (up) n_proc = v; else n_main = v;
        end
        if (wr_main) n_main = {wr_data[31:2], 2'b00};
        if (wr_proc) n_proc = {wr_data[31:2], 2'b00};
        if (boot_vld) n_main = {boot_word[31:2], 2'b00};
        n_ctl = ctrl_wr ? ctrl_wdata : m_ctl;
        n_hnd = m_hnd;
        if (exc_entry) n_hnd = 1'b1;
        else if (exc_return && m_hnd && exc_code[3]) begin
            n_hnd = 1'b0; n_ctl[1] = exc_code[2];
        end
        if (wr_proc) m_known = 1'b1;
        m_main = n_main; m_proc = n_proc; m_ctl = n_ctl; m_hnd = n_hnd;
        @(posedge clk);
        @(negedge clk);
        idle();
        chk({tag, " sp_main"}, sp_main, m_main);
        if (m_known) chk({tag, " sp_proc"}, sp_proc, m_proc);
        chk({tag, " ctrl_rd R3"}, 32'(ctrl_rd), 32'(m_ctl));
        chk({tag, " in_handler R9 R10"}, 32'(in_handler), 32'(m_hnd));
        chk({tag, " proc_active R3 R4"}, 32'(proc_active), 32'(m_use_proc()));
        if (!m_use_proc() || m_known)
            chk({tag, " sp_active"}, sp_active, m_use_proc() ? m_proc : m_main);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_main = '0; m_proc = '0; m_hnd = 0; m_ctl = '0; m_known = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 sp_main", sp_main, 32'd0);
        chk("R1 ctrl_rd", 32'(ctrl_rd), 32'd0);
        chk("R1 in_handler", 32'(in_handler), 32'd0);
        chk("R1 proc_active", 32'(proc_active), 32'd0);

        // R2 boot load with unaligned word
        boot_vld = 1; boot_word = 32'h2000_0403; wr_main = 1; wr_data = 32'h5555_5554;
        step("R2 boot");
        chk("R2 boot value", sp_main, 32'h2000_0400);

        // R7 software write clears low bits
        wr_proc = 1; wr_data = 32'h1000_0107;
        step("R7 wr_proc");
        chk("R7 proc aligned", sp_proc, 32'h1000_0104);

        push_req = 1;
        #1 chk("R5 push addr", stk_addr, 32'h2000_03FC);
        step("R5 push");
        chk("R5 main after push", sp_main, 32'h2000_03FC);

        push_req = 1; pop_req = 1;
        step("R6 push+pop");
        chk("R6 push wins", sp_main, 32'h2000_03F8);

        pop_req = 1;
        #1 chk("R6 pop addr", stk_addr, 32'h2000_03F8);
        step("R6 pop");
        chk("R6 main after pop", sp_main, 32'h2000_03FC);

        ctrl_wr = 1; ctrl_wdata = 2'b11;
        step("R3 select proc");
        chk("R3 active is proc", sp_active, 32'h1000_0104);

        // R11 push with entry: pre-event pointer (proc) is used
        push_req = 1; exc_entry = 1;
        step("R11 push+entry");
        chk("R11 proc decremented", sp_proc, 32'h1000_0100);
        chk("R9 handler active main", sp_active, 32'h2000_03FC);

        ctrl_wr = 1; ctrl_wdata = 2'b10;
        step("R4 ctrl in handler");
        chk("R4 main still active", 32'(proc_active), 32'd0);

        push_req = 1;
        step("R4 push in handler");
        chk("R4 main pushed", sp_main, 32'h2000_03F8);

        exc_return = 1; exc_code = 32'hFFFF_FFF1;
        step("R10 nested return");
        chk("R10 stays handler", 32'(in_handler), 32'd1);

        exc_return = 1; exc_code = 32'hFFFF_FFFD; ctrl_wr = 1; ctrl_wdata = 2'b01;
        step("R11 return+ctrl");
        chk("R11 return sel wins", 32'(ctrl_rd), 32'd3);

        exc_return = 1; exc_code = 32'hFFFF_FFF9;
        step("R10 return in thread ignored");
        chk("R10 sel kept", 32'(proc_active), 32'd1);

        wr_proc = 1; wr_data = 32'h3000_0000; push_req = 1;
        step("R8 write vs push");
        chk("R8 write wins", sp_proc, 32'h3000_0000);

        exc_entry = 1; exc_return = 1; exc_code = 32'hFFFF_FFFD;
        step("R11 entry+return");
        chk("R11 entry wins", 32'(in_handler), 32'd1);

        // random mix against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            push_req   = (r[3:0] < 4'd5);
            pop_req    = (r[7:4] < 4'd5);
            wr_main    = (r[11:8] == 4'd0);
            wr_proc    = (r[15:12] == 4'd0);
            ctrl_wr    = (r[19:16] < 4'd2);
            ctrl_wdata = r[21:20];
            exc_entry  = (r[25:22] == 4'd0);
            exc_return = (r[29:26] < 4'd2);
            boot_vld   = (r[31:28] == 4'hF) && r[0];
            wr_data    = $urandom;
            boot_word  = $urandom;
            exc_code   = {28'hFFFF_FFF, $urandom_range(0, 15)[3:0]};
            step("R5 R6 R8 R10 R11 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule